// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Byte Mode

This block is the combinational arithmetic and logic unit of a small 16-bit processor core. Each cycle the surrounding datapath presents an operation code, a source word, a destination word, the current status bits and a byte/word select. The unit returns the result, a write-enable telling the datapath whether the result goes back to the destination, and the next status bits. Register storage, operand fetch, the stack and program flow stay outside.

Two groups of operations are covered. The two-operand group holds moves, binary and decimal addition, subtraction with and without carry, compare, bit test and the bitwise set, clear, exclusive-or and and. The one-operand group holds the right shift, the rotate through carry, the byte swap and the sign extension, and it is picked by a two-bit selector under one operation code. Byte mode narrows the two-operand group, the right shift and the rotate to the low eight bits.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0x4 moves the source to the result with write-enable high and all four status bits unchanged; the status vector is {V,N,Z,C} at bits 3,2,1,0.
- R2: Codes 0x5, 0x6, 0x7 and 0x8 give dst+src, dst+src+C, dst+(not src)+C and dst+(not src)+1; C is the carry out of the active width, V is signed overflow, N is the result's top bit and Z flags a zero result.
- R3: Code 0x9 sets the status bits exactly as 0x8 would and code 0xB sets them exactly as 0xF would, and both hold write-enable low.
- R4: Code 0xA adds source, destination and C as packed decimal digits; C is set when the sum exceeds 9999 (99 in byte mode), V is cleared, N and Z follow the result.
- R5: Codes 0xF (and) and 0xE (exclusive-or) set C to the inverse of Z; V is cleared for 0xF and for 0xE is set only when both operands are negative.
- R6: Code 0xC returns (not src) and dst, code 0xD returns src or dst, and both leave the status bits unchanged.
- R7: With byte select high, every operation except the swap and the sign extension uses only operand bits 7..0, takes N, C and V at bit 7 and Z from the low byte, and returns zero in result bits 15..8.
- R8: Code 0x1 with selector 0 rotates the destination right through carry and selector 2 shifts it right keeping its top bit; in both the old bit 0 goes to C, V is cleared and N and Z follow the result.
- R9: Code 0x1 with selector 1 swaps the two bytes with status unchanged, and selector 3 copies bit 7 into bits 15..8 with C equal to the inverse of Z and V cleared; both ignore the byte select.
- R10: Codes 0x0, 0x2 and 0x3 hold write-enable low, return a zero result and leave the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| sel_i | input | 2 | One-operand selector, used with code 0x1 |
| src_i | input | W | Source operand |
| dst_i | input | W | Destination operand, also the one-operand input |
| byte_i | input | 1 | High for byte operation, low for word |
| stat_i | input | 4 | Current status bits {V,N,Z,C} |
| res_o | output | W | Operation result |
| we_o | output | 1 | High when the result is to be written back |
| stat_o | output | 4 | Next status bits {V,N,Z,C} |

## Verification
Since the unit holds no state, a wrong internal value reaches the ports in the same cycle the inputs arrive: a bad adder carry chain shows as a wrong C or V, a wrong decimal correction shows as an off digit in the result, and a faulty byte mask leaks bits into the upper byte. The stimulus mixes directed edges (signed overflow at 0x7FFF, byte wrap at 0xFF, decimal roll-over at 9999 and 99, rotate with carry set) with seeded random vectors across every code, selector and mode, and compares each vector against an arithmetic model built on integer and decimal values rather than bit logic.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

   localparam logic [3:0] OP_UNARY = 4'h1;
   localparam logic [3:0] OP_MOV   = 4'h4;
   localparam logic [3:0] OP_ADD   = 4'h5;
   localparam logic [3:0] OP_ADDC  = 4'h6;
   localparam logic [3:0] OP_SUBC  = 4'h7;
   localparam logic [3:0] OP_SUB   = 4'h8;
   localparam logic [3:0] OP_CMP   = 4'h9;
   localparam logic [3:0] OP_DADD  = 4'hA;
   localparam logic [3:0] OP_BIT   = 4'hB;
   localparam logic [3:0] OP_BIC   = 4'hC;
   localparam logic [3:0] OP_BIS   = 4'hD;
   localparam logic [3:0] OP_XOR   = 4'hE;
   localparam logic [3:0] OP_AND   = 4'hF;

   localparam logic [1:0] SEL_RRC  = 2'd0;
   localparam logic [1:0] SEL_SWPB = 2'd1;
   localparam logic [1:0] SEL_RRA  = 2'd2;
   localparam logic [1:0] SEL_SXT  = 2'd3;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      FK_HOLD,
      FK_ARITH,
      FK_DEC,
      FK_LOGIC,
      FK_XOR,
      FK_SHIFT,
      FK_SXT
   } flag_kind_e;

endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
module alu16_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         byte_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   localparam int BW = alu16_pkg::BYTE_W;

   logic [W:0] full;
   logic       a_top, b_top, r_top;

   assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   assign sum_o  = full[W-1:0];
   assign cout_o = byte_i ? full[BW] : full[W];
   assign a_top  = byte_i ? a_i[BW-1] : a_i[W-1];
   assign b_top  = byte_i ? b_i[BW-1] : b_i[W-1];
   assign r_top  = byte_i ? full[BW-1] : full[W-1];
   assign ovf_o  = (a_top == b_top) && (r_top != a_top);
endmodule

// File: rtl/alu16_bcd.sv
`timescale 1ns/1ps
module alu16_bcd #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         byte_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   localparam int NDIG      = W / 4;
   localparam int BYTE_DIGS = alu16_pkg::BYTE_W / 4;

   logic [NDIG:0] dc;
   assign dc[0] = cin_i;

   for (genvar d = 0; d < NDIG; d++) begin : g_digit
      logic [4:0] raw;
      logic       adj;
      assign raw = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'b0, dc[d]};
      assign adj = (raw > 5'd9);
      assign sum_o[4*d +: 4] = adj ? (raw[3:0] + 4'd6) : raw[3:0];
      assign dc[d+1] = adj;
   end

   assign cout_o = byte_i ? dc[BYTE_DIGS] : dc[NDIG];
endmodule

// File: rtl/alu16_unary.sv
`timescale 1ns/1ps
module alu16_unary
   import alu16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [1:0]   sel_i,
   input  logic         cin_i,
   input  logic         byte_i,
   output logic [W-1:0] r_o,
   output logic         cout_o
);
   localparam int BW = BYTE_W;
   localparam int HI = W - BW;

   logic [W-1:0] xm;
   logic         fill;

   assign xm     = byte_i ? {{HI{1'b0}}, x_i[BW-1:0]} : x_i;
   assign cout_o = xm[0];
   assign fill   = (sel_i == SEL_RRC) ? cin_i : (byte_i ? xm[BW-1] : xm[W-1]);

   always_comb begin
      r_o = xm >> 1;
      case (sel_i)
         SEL_RRC, SEL_RRA: begin
            if (byte_i) r_o[BW-1] = fill;
            else        r_o[W-1]  = fill;
         end
         SEL_SWPB: begin
            r_o = x_i;
            r_o[2*BW-1:0] = {x_i[BW-1:0], x_i[2*BW-1:BW]};
         end
         default: r_o = {{HI{x_i[BW-1]}}, x_i[BW-1:0]};
      endcase
   end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
   import alu16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [3:0]   op_i,
   input  logic [1:0]   sel_i,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] dst_i,
   input  logic         byte_i,
   input  logic [3:0]   stat_i,
   output logic [W-1:0] res_o,
   output logic         we_o,
   output logic [3:0]   stat_o
);
   localparam int BW = BYTE_W;
   localparam int HI = W - BW;

   if (W < 2*BW || (W % 4) != 0 || (W % BW) != 0) begin : g_bad_width
      $error("alu16_core: W must be a multiple of 8 and at least 16");
   end

   logic [W-1:0] mask, sm, dm, as_b, as_sum, bcd_sum, un_res;
   logic         is_sub, as_cin, as_cout, as_ovf, bcd_cout, un_cout;
   logic         wide, nf, zf, src_top, dst_top;
   flag_kind_e   kind;

   assign mask = byte_i ? {{HI{1'b0}}, {BW{1'b1}}} : {W{1'b1}};
   assign sm   = src_i & mask;
   assign dm   = dst_i & mask;

   assign is_sub = (op_i == OP_SUBC) || (op_i == OP_SUB) || (op_i == OP_CMP);
   assign as_b   = is_sub ? (~src_i & mask) : sm;

   always_comb begin
      case (op_i)
         OP_ADDC, OP_SUBC: as_cin = stat_i[FLG_C];
         OP_SUB, OP_CMP:   as_cin = 1'b1;
         default:          as_cin = 1'b0;
      endcase
   end

   alu16_addsub #(.W(W)) u_addsub (
      .a_i(dm), .b_i(as_b), .cin_i(as_cin), .byte_i(byte_i),
      .sum_o(as_sum), .cout_o(as_cout), .ovf_o(as_ovf)
   );

   alu16_bcd #(.W(W)) u_bcd (
      .a_i(dm), .b_i(sm), .cin_i(stat_i[FLG_C]), .byte_i(byte_i),
      .sum_o(bcd_sum), .cout_o(bcd_cout)
   );

   alu16_unary #(.W(W)) u_unary (
      .x_i(dst_i), .sel_i(sel_i), .cin_i(stat_i[FLG_C]), .byte_i(byte_i),
      .r_o(un_res), .cout_o(un_cout)
   );

   always_comb begin
      res_o = '0;
      we_o  = 1'b0;
      kind  = FK_HOLD;
      case (op_i)
         OP_MOV: begin res_o = sm; we_o = 1'b1; end
         OP_ADD, OP_ADDC, OP_SUBC, OP_SUB: begin
            res_o = as_sum & mask; we_o = 1'b1; kind = FK_ARITH;
         end
         OP_CMP:  begin res_o = as_sum & mask; kind = FK_ARITH; end
         OP_DADD: begin res_o = bcd_sum & mask; we_o = 1'b1; kind = FK_DEC; end
         OP_BIT:  begin res_o = sm & dm; kind = FK_LOGIC; end
         OP_AND:  begin res_o = sm & dm; we_o = 1'b1; kind = FK_LOGIC; end
         OP_BIC:  begin res_o = ~src_i & dm; we_o = 1'b1; end
         OP_BIS:  begin res_o = sm | dm; we_o = 1'b1; end
         OP_XOR:  begin res_o = sm ^ dm; we_o = 1'b1; kind = FK_XOR; end
         OP_UNARY: begin
            res_o = un_res;
            we_o  = 1'b1;
            case (sel_i)
               SEL_RRC, SEL_RRA: kind = FK_SHIFT;
               SEL_SXT:          kind = FK_SXT;
               default:          kind = FK_HOLD;
            endcase
         end
         default: ;
      endcase
   end

   assign wide    = !byte_i || (op_i == OP_UNARY && (sel_i == SEL_SWPB || sel_i == SEL_SXT));
   assign nf      = wide ? res_o[W-1] : res_o[BW-1];
   assign zf      = wide ? (res_o == '0) : (res_o[BW-1:0] == '0);
   assign src_top = byte_i ? src_i[BW-1] : src_i[W-1];
   assign dst_top = byte_i ? dst_i[BW-1] : dst_i[W-1];

   always_comb begin
      case (kind)
         FK_ARITH: stat_o = {as_ovf, nf, zf, as_cout};
         FK_DEC:   stat_o = {1'b0, nf, zf, bcd_cout};
         FK_LOGIC: stat_o = {1'b0, nf, zf, !zf};
         FK_XOR:   stat_o = {src_top & dst_top, nf, zf, !zf};
         FK_SHIFT: stat_o = {1'b0, nf, zf, un_cout};
         FK_SXT:   stat_o = {1'b0, nf, zf, !zf};
         default:  stat_o = stat_i;
      endcase
   end
endmodule

// File: rtl/alu16_core_chk.sv
`timescale 1ns/1ps
module alu16_core_chk
   import alu16_pkg::*;
#(
   parameter int W = 16
) (
   input logic [3:0]   op_i,
   input logic [1:0]   sel_i,
   input logic         byte_i,
   input logic [3:0]   stat_i,
   input logic [W-1:0] res_o,
   input logic         we_o,
   input logic [3:0]   stat_o
);
   localparam int BW = BYTE_W;

   logic unary_wide;
   assign unary_wide = (op_i == OP_UNARY) && (sel_i == SEL_SWPB || sel_i == SEL_SXT);

   always_comb begin
      if (op_i == OP_MOV)
         assert_mov_flags_R1: assert (we_o && stat_o == stat_i)
            else $error("MOV altered status or skipped write");
      if (op_i == OP_CMP || op_i == OP_BIT)
         assert_test_no_write_R3: assert (!we_o)
            else $error("test-only operation asserted write");
      if (op_i == OP_DADD)
         assert_dadd_v_clear_R4: assert (!stat_o[FLG_V])
            else $error("decimal add left V set");
      if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR)
         assert_logic_c_not_z_R5: assert (stat_o[FLG_C] == !stat_o[FLG_Z])
            else $error("logic op C is not the inverse of Z");
      if (op_i == OP_BIC || op_i == OP_BIS)
         assert_bitset_flags_R6: assert (stat_o == stat_i)
            else $error("bit set/clear altered status");
      if (byte_i && !unary_wide)
         assert_byte_upper_zero_R7: assert (res_o[W-1:BW] == '0)
            else $error("byte mode leaked into upper result bits");
      if (op_i == OP_UNARY && sel_i == SEL_RRC)
         assert_rrc_top_from_c_R8: assert ((byte_i ? res_o[BW-1] : res_o[W-1]) == stat_i[FLG_C])
            else $error("rotate did not insert carry at the top");
      if (op_i == OP_UNARY && sel_i == SEL_SWPB)
         assert_swpb_flags_R9: assert (stat_o == stat_i)
            else $error("byte swap altered status");
      if (op_i == OP_UNARY && sel_i == SEL_SXT)
         assert_sxt_upper_R9: assert (res_o[W-1:BW] == {(W-BW){res_o[BW-1]}})
            else $error("sign extension upper bits wrong");
      if (op_i == 4'h0 || op_i == 4'h2 || op_i == 4'h3)
         assert_unused_idle_R10: assert (!we_o && stat_o == stat_i && res_o == '0)
            else $error("unused code produced activity");
   end
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
   .op_i(op_i), .sel_i(sel_i), .byte_i(byte_i), .stat_i(stat_i),
   .res_o(res_o), .we_o(we_o), .stat_o(stat_o)
);

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic [1:0]  sel;
   logic [15:0] src, dst;
   logic        bm;
   logic [3:0]  st;
   logic [15:0] res;
   logic        we;
   logic [3:0]  st_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   alu16_core #(.W(16)) u0 (
      .op_i(op), .sel_i(sel), .src_i(src), .dst_i(dst), .byte_i(bm),
      .stat_i(st), .res_o(res), .we_o(we), .stat_o(st_o)
   );

   function automatic int sx(input int x, input int n);
      return (x >= (1 << (n-1))) ? x - (1 << n) : x;
   endfunction

   function automatic int bcd_dec(input logic [15:0] x, input int ndig);
      int v = 0;
      for (int d = ndig-1; d >= 0; d--) v = v*10 + int'((x >> (4*d)) & 16'hF);
      return v;
   endfunction

   function automatic logic [15:0] bcd_enc(input int v, input int ndig);
      logic [15:0] r = '0;
      for (int d = 0; d < ndig; d++) begin
         r = r | (16'(v % 10) << (4*d));
         v = v / 10;
      end
      return r;
   endfunction

   function automatic logic [15:0] rand_bcd();
      logic [15:0] r = '0;
      for (int d = 0; d < 4; d++) r = r | (16'($urandom % 10) << (4*d));
      return r;
   endfunction

   function automatic void model(input logic [3:0] o, input logic [1:0] s,
                                 input logic [15:0] a_src, input logic [15:0] a_dst,
                                 input logic b, input logic [3:0] si,
                                 output logic [15:0] r, output logic w, output logic [3:0] so);
      int n, m, a, bb, ci, sum, sr, lim;
      logic c, v, ng, z;
      n = b ? 8 : 16;
      m = (1 << n) - 1;
      ci = int'(si[0]);
      r = '0; w = 1'b1; so = si;
      case (o)
         4'h4: r = 16'(int'(a_src) & m);
         4'h5, 4'h6, 4'h7, 4'h8, 4'h9: begin
            a  = int'(a_dst) & m;
            bb = (o >= 4'h7) ? (int'(~a_src) & m) : (int'(a_src) & m);
            ci = (o == 4'h5) ? 0 : ((o >= 4'h8) ? 1 : ci);
            sum = a + bb + ci;
            r  = 16'(sum & m);
            c  = ((sum >> n) & 1) != 0;
            sr = sx(a, n) + sx(bb, n) + ci;
            v  = (sr > (1 << (n-1)) - 1) || (sr < -(1 << (n-1)));
            ng = ((int'(r) >> (n-1)) & 1) != 0;
            so = {v, ng, r == 0, c};
            w  = (o != 4'h9);
         end
         4'hA: begin
            lim = b ? 100 : 10000;
            sum = bcd_dec(16'(int'(a_dst) & m), n/4) + bcd_dec(16'(int'(a_src) & m), n/4) + ci;
            r  = bcd_enc(sum % lim, n/4);
            ng = ((int'(r) >> (n-1)) & 1) != 0;
            so = {1'b0, ng, r == 0, sum >= lim};
         end
         4'hB, 4'hF, 4'hE: begin
            r  = (o == 4'hE) ? 16'((int'(a_src) ^ int'(a_dst)) & m) : 16'(int'(a_src) & int'(a_dst) & m);
            ng = ((int'(r) >> (n-1)) & 1) != 0;
            z  = (r == 0);
            v  = (o == 4'hE) && (((int'(a_src) >> (n-1)) & 1) != 0) && (((int'(a_dst) >> (n-1)) & 1) != 0);
            so = {v, ng, z, !z};
            w  = (o != 4'hB);
         end
         4'hC: r = 16'(int'(~a_src) & int'(a_dst) & m);
         4'hD: r = 16'((int'(a_src) | int'(a_dst)) & m);
         4'h1: begin
            a = int'(a_dst) & m;
            case (s)
               2'd0, 2'd2: begin
                  if (s == 2'd0) r = 16'((a >> 1) | (ci << (n-1)));
                  else           r = 16'((a >> 1) | (a & (1 << (n-1))));
                  ng = ((int'(r) >> (n-1)) & 1) != 0;
                  so = {1'b0, ng, r == 0, (a & 1) != 0};
               end
               2'd1: r = {a_dst[7:0], a_dst[15:8]};
               default: begin
                  r = {{8{a_dst[7]}}, a_dst[7:0]};
                  so = {1'b0, r[15], r == 0, r != 0};
               end
            endcase
         end
         default: begin r = '0; w = 1'b0; end
      endcase
   endfunction

   function automatic string req_tag(input logic [3:0] o, input logic [1:0] s, input logic b);
      string t;
      case (o)
         4'h4: t = "R1";
         4'h5, 4'h6, 4'h7, 4'h8: t = "R2";
         4'h9, 4'hB: t = "R3";
         4'hA: t = "R4";
         4'hE, 4'hF: t = "R5";
         4'hC, 4'hD: t = "R6";
         4'h1: t = (s == 2'd0 || s == 2'd2) ? "R8" : "R9";
         default: t = "R10";
      endcase
      if (b && !(o == 4'h1 && (s == 2'd1 || s == 2'd3)) && o != 4'h0 && o != 4'h2 && o != 4'h3)
         t = {t, "/R7"};
      return t;
   endfunction

   task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [15:0] a_src,
                      input logic [15:0] a_dst, input logic b, input logic [3:0] si);
      logic [15:0] er; logic ew; logic [3:0] es;
      @(posedge clk);
      op = o; sel = s; src = a_src; dst = a_dst; bm = b; st = si;
      model(o, s, a_src, a_dst, b, si, er, ew, es);
      @(negedge clk);
      checks++;
      if (res !== er || we !== ew || st_o !== es) begin
         failures++;
         $display("FAIL %s op=%h sel=%0d src=%h dst=%h byte=%b stat=%b: got res=%h we=%b stat=%b, exp res=%h we=%b stat=%b",
                  req_tag(o, s, b), o, s, a_src, a_dst, b, si, res, we, st_o, er, ew, es);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout, exp completion");
      finish_run();
   end

   initial begin
      logic [3:0]  o;
      logic [15:0] a, d;
      void'($urandom(32'd20240611));
      op = 4'h0; sel = 2'd0; src = '0; dst = '0; bm = 1'b0; st = 4'h0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state with all-zero inputs: unused code 0, no write (R10)
      @(negedge clk);
      checks++;
      if (res !== 16'h0 || we !== 1'b0 || st_o !== 4'h0) begin
         failures++;
         $display("FAIL R10 idle: got res=%h we=%b stat=%b, exp res=0000 we=0 stat=0000", res, we, st_o);
      end
      // directed corners
      run(4'h4, 2'd0, 16'hBEEF, 16'h1234, 1'b0, 4'hA);   // R1 move keeps status
      run(4'h4, 2'd0, 16'hBEEF, 16'h1234, 1'b1, 4'h5);   // R1 R7 byte move
      run(4'h5, 2'd0, 16'h0001, 16'h7FFF, 1'b0, 4'h0);   // R2 signed overflow
      run(4'h5, 2'd0, 16'h0001, 16'h00FF, 1'b1, 4'h0);   // R2 R7 byte wrap, carry out
      run(4'h6, 2'd0, 16'hFFFF, 16'h0000, 1'b0, 4'h1);   // R2 carry in ripples
      run(4'h8, 2'd0, 16'h1234, 16'h1234, 1'b0, 4'h0);   // R2 equal subtract
      run(4'h7, 2'd0, 16'h0001, 16'h0000, 1'b0, 4'h0);   // R2 borrow path
      run(4'h9, 2'd0, 16'h8000, 16'h7FFF, 1'b0, 4'h0);   // R3 compare overflow, no write
      run(4'hB, 2'd0, 16'h00F0, 16'h0F00, 1'b0, 4'hF);   // R3 bit test zero
      run(4'hA, 2'd0, 16'h0001, 16'h9999, 1'b0, 4'h0);   // R4 decimal roll-over
      run(4'hA, 2'd0, 16'h1201, 16'h3499, 1'b1, 4'h0);   // R4 R7 byte decimal roll-over
      run(4'hA, 2'd0, 16'h0458, 16'h1267, 1'b0, 4'h1);   // R4 with carry in
      run(4'hE, 2'd0, 16'h8001, 16'hF000, 1'b0, 4'h0);   // R5 xor both negative
      run(4'hE, 2'd0, 16'h0081, 16'h0080, 1'b1, 4'h0);   // R5 R7 byte xor
      run(4'hF, 2'd0, 16'h0F0F, 16'hF0F0, 1'b0, 4'h0);   // R5 and zero
      run(4'hC, 2'd0, 16'h00FF, 16'hFFFF, 1'b0, 4'h6);   // R6 clear keeps status
      run(4'hD, 2'd0, 16'hA000, 16'h0005, 1'b1, 4'h9);   // R6 R7 set in byte mode
      run(4'h1, 2'd0, 16'h0000, 16'h0002, 1'b0, 4'h1);   // R8 rotate in carry
      run(4'h1, 2'd0, 16'h0000, 16'hAB03, 1'b1, 4'h1);   // R8 R7 byte rotate
      run(4'h1, 2'd2, 16'h0000, 16'h8001, 1'b0, 4'h0);   // R8 shift keeps sign
      run(4'h1, 2'd1, 16'h0000, 16'h12AB, 1'b1, 4'h3);   // R9 swap ignores byte select
      run(4'h1, 2'd3, 16'h0000, 16'h0080, 1'b1, 4'h0);   // R9 extend ignores byte select
      run(4'h1, 2'd3, 16'h0000, 16'hFF00, 1'b0, 4'h0);   // R9 extend to zero
      run(4'h2, 2'd0, 16'hFFFF, 16'hFFFF, 1'b0, 4'hC);   // R10 unused code
      run(4'h3, 2'd3, 16'h1111, 16'h2222, 1'b1, 4'h3);   // R10 unused code
      // seeded random sweep over all codes and modes
      for (int i = 0; i < 4000; i++) begin
         o = 4'($urandom % 16);
         a = 16'($urandom);
         d = 16'($urandom);
         if (o == 4'hA) begin a = rand_bcd(); d = rand_bcd(); end
         run(o, 2'($urandom % 4), a, d, 1'($urandom % 2), 4'($urandom % 16));
      end
      finish_run();
   end
endmodule